// File: doc/BRIEF.md
# Handshaked I2C Bus Master

This block is a single-master I2C engine run by a processor through three small registers: a byte register, a control register and a read-only status register. Software asks for a START, loads an address or data byte and lets the engine move the bus one step. After every step the engine stops with SCL held low and raises an interrupt flag. It also publishes a fixed one-byte code that names what has just happened on the wire. The engine stays parked until software clears the flag. The control bits software writes in that same access pick the next step: STOP, a new START, another byte, or an ACK or NACK for the next received byte.

SCL comes from a divider of the system clock. Each bit spends `QUARTER` cycles in each of four quarter-phases, and `QUARTER` must be at least 2. Both lines are open-drain: the block only reports when it pulls a line low, and it reads the wired bus level back. A 1 that the block sends but reads back as 0 on the SDA line means it has lost arbitration. It then lets go of both lines and reports the loss.

Register map (`regAddr`): 0 is the byte register, read/write. 1 is control: bit 0 acknowledge-enable, bit 1 STOP request, bit 2 START request, bit 3 interrupt flag. Writing 0 to bit 3 clears the flag and writing 1 to it leaves the flag unchanged. 2 is status, read-only. 3 reads 0.

Top module: `i2cStsMaster`

## Requirements
- R1: After reset the status reads F8h, the control register reads 00h, the interrupt output is 0 and neither line is pulled low.
- R2: With the START request set and both lines high, the block makes a START (SDA falls while SCL is high, then SCL falls), clears the START request, sets the flag and reports 08h.
- R3: The flag is 0 whenever the block is idle. The idle status is F8h.
- R4: Clearing the flag after 08h sends the byte register as the address byte, MSB first, with bit 0 as direction (1 = read). Status becomes 18h (write, ACK), 20h (write, no ACK), 40h (read, ACK) or 48h (read, no ACK).
- R5: In write mode, clearing the flag sends the byte register as data. Status becomes 28h when the slave ACKs and 30h when it does not.
- R6: In read mode, clearing the flag receives one byte into the byte register. With acknowledge-enable at 1 the block drives ACK (SDA low) in the ninth bit and reports 50h. With acknowledge-enable at 0 it leaves SDA high (NACK) and reports 58h.
- R7: When a transmitted 1 reads back as 0 while SCL is high, the block releases both lines and reports 38h with the flag set.
- R8: After 38h, clearing the flag with START at 0 returns the block to idle (F8h, flag 0). Clearing it with START at 1 makes the block wait until both lines are high, then send a START and report 08h.
- R9: Clearing the flag with the STOP request set makes a STOP (SDA rises while SCL is high). The STOP request then clears itself, the status returns to F8h and the flag stays 0.
- R10: While the flag is set, neither line changes.
- R11: During a byte, SCL stays high for 2*QUARTER clock cycles per bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 2 | Register select |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Register read data (combinational) |
| irq | output | 1 | Interrupt flag |
| sclIn | input | 1 | Wired SCL level |
| sdaIn | input | 1 | Wired SDA level |
| sclLow | output | 1 | 1 pulls SCL low |
| sdaLow | output | 1 | 1 pulls SDA low |

## Verification
A register write lands on the next clock edge. The engine starts its bus step one cycle after the flag is cleared. A START or STOP then takes 4*QUARTER cycles and a byte takes 36*QUARTER cycles, and the flag and status appear two cycles after the last quarter-phase. Because the byte and START latencies depend only on `QUARTER`, the bench waits on the interrupt output with a bounded poll at falling clock edges. It reads the status in that same sample. STOP produces no flag, so the bench polls the status and control registers until they settle. The check fails if this does not happen within a bound. A bus model in the bench answers at falling clock edges after each SCL edge, so its replies never race the design's registered line drives.

// File: rtl/i2cStsPkg.sv
package i2cStsPkg;

  // strobes from the control FSM to the bit engine
  typedef struct packed {
    logic start;
    logic stop;
    logic byteGo;
    logic rxMode;
    logic ackOut;
  } dpCmd_t;

  localparam logic [1:0] REG_DATA   = 2'd0;
  localparam logic [1:0] REG_CTL    = 2'd1;
  localparam logic [1:0] REG_STATUS = 2'd2;

  localparam int CTL_ACK   = 0;
  localparam int CTL_STOP  = 1;
  localparam int CTL_START = 2;
  localparam int CTL_FLAG  = 3;

  localparam logic [7:0] ST_START   = 8'h08;
  localparam logic [7:0] ST_AW_ACK  = 8'h18;
  localparam logic [7:0] ST_AW_NACK = 8'h20;
  localparam logic [7:0] ST_TX_ACK  = 8'h28;
  localparam logic [7:0] ST_TX_NACK = 8'h30;
  localparam logic [7:0] ST_LOST    = 8'h38;
  localparam logic [7:0] ST_AR_ACK  = 8'h40;
  localparam logic [7:0] ST_AR_NACK = 8'h48;
  localparam logic [7:0] ST_RX_ACK  = 8'h50;
  localparam logic [7:0] ST_RX_NACK = 8'h58;
  localparam logic [7:0] ST_IDLE    = 8'hF8;

endpackage

// File: rtl/i2cStsBitEngine.sv
module i2cStsBitEngine
  import i2cStsPkg::*;
#(
  parameter int QUARTER = 25
) (
  input  logic       clk,
  input  logic       rstN,
  input  dpCmd_t     cmd,
  input  logic [7:0] txByte,
  input  logic       sdaIn,
  output logic       sclLow,
  output logic       sdaLow,
  output logic       done,
  output logic       lost,
  output logic       ackIn,
  output logic [7:0] rxByte
);

  localparam int DIV_W = (QUARTER > 1) ? $clog2(QUARTER) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(QUARTER - 1);
  localparam logic [3:0] ACK_BIT = 4'd8;

  typedef enum logic [1:0] {opIdle, opStart, opStop, opByte} op_e;

  op_e             op;
  logic [1:0]      phase;
  logic [3:0]      bitCnt;
  logic [DIV_W-1:0] divCnt;
  logic [7:0]      shiftReg;
  logic            rxMode;
  logic            ackOutQ;
  logic            tick;

  assign tick   = (divCnt == DIV_LAST);
  assign rxByte = shiftReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      op       <= opIdle;
      phase    <= '0;
      bitCnt   <= '0;
      divCnt   <= '0;
      sclLow   <= 1'b0;
      sdaLow   <= 1'b0;
      shiftReg <= '0;
      rxMode   <= 1'b0;
      ackOutQ  <= 1'b0;
      ackIn    <= 1'b0;
      lost     <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (op == opIdle) begin
        divCnt <= '0;
        phase  <= '0;
        bitCnt <= '0;
        if (cmd.start) begin
          op   <= opStart;
          lost <= 1'b0;
        end else if (cmd.stop) begin
          op <= opStop;
        end else if (cmd.byteGo) begin
          op       <= opByte;
          shiftReg <= txByte;
          rxMode   <= cmd.rxMode;
          ackOutQ  <= cmd.ackOut;
          lost     <= 1'b0;
        end
      end else if (tick) begin
        divCnt <= '0;
        phase  <= phase + 2'd1;
        unique case (op)
          opStart: begin
            unique case (phase)
              2'd0: sdaLow <= 1'b0;
              2'd1: sclLow <= 1'b0;
              2'd2: sdaLow <= 1'b1;
              default: begin
                sclLow <= 1'b1;
                op     <= opIdle;
                done   <= 1'b1;
              end
            endcase
          end
          opStop: begin
            unique case (phase)
              2'd0: sdaLow <= 1'b1;
              2'd1: sclLow <= 1'b0;
              2'd2: sdaLow <= 1'b0;
              default: begin
                op   <= opIdle;
                done <= 1'b1;
              end
            endcase
          end
          default: begin
            unique case (phase)
              2'd0: sdaLow <= (bitCnt == ACK_BIT) ? (rxMode & ackOutQ)
                                                  : (!rxMode & !shiftReg[7]);
              2'd1: sclLow <= 1'b0;
              2'd2: begin
                if (bitCnt == ACK_BIT) begin
                  ackIn <= !sdaIn;
                end else if (!rxMode && shiftReg[7] && !sdaIn) begin
                  lost   <= 1'b1;
                  sclLow <= 1'b0;
                  sdaLow <= 1'b0;
                  op     <= opIdle;
                  done   <= 1'b1;
                end else begin
                  shiftReg <= {shiftReg[6:0], sdaIn};
                end
              end
              default: begin
                sclLow <= 1'b1;
                if (bitCnt == ACK_BIT) begin
                  op   <= opIdle;
                  done <= 1'b1;
                end else begin
                  bitCnt <= bitCnt + 4'd1;
                end
              end
            endcase
          end
        endcase
      end else begin
        divCnt <= divCnt + 1'b1;
      end
    end
  end

  // a lost master must have let go of both lines when it reports
  assert_lost_release_R7: assert property (@(posedge clk) disable iff (!rstN)
    (done && lost) |-> (!sclLow && !sdaLow));

  // in receive mode no data bit is ever driven low by the master
  assert_rx_no_drive_R6: assert property (@(posedge clk) disable iff (!rstN)
    (op == opByte && rxMode && bitCnt != ACK_BIT && phase == 2'd2) |-> !sdaLow);

endmodule

// File: rtl/i2cStsCtrl.sv
module i2cStsCtrl
  import i2cStsPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWe,
  input  logic [1:0] regAddr,
  input  logic [7:0] regWdata,
  output logic [7:0] regRdata,
  output logic       flag,
  output logic [7:0] statusCode,
  output dpCmd_t     cmd,
  output logic [7:0] txByte,
  input  logic       busFree,
  input  logic       dpDone,
  input  logic       dpLost,
  input  logic       dpAckIn,
  input  logic [7:0] dpRxByte
);

  typedef enum logic [1:0] {cIdle, cBusy, cHold} state_e;
  typedef enum logic [2:0] {pStart, pAddr, pTx, pRx, pStop} pend_e;
  typedef enum logic [1:0] {nxAddr, nxTx, nxRx, nxLost} next_e;

  state_e     state;
  pend_e      pend;
  next_e      nextAct;
  logic [7:0] dataReg;
  logic       ackEn, stopReq, startReq, readMode, ackSent;

  assign txByte = dataReg;

  always_comb begin
    unique case (regAddr)
      REG_DATA:   regRdata = dataReg;
      REG_CTL:    regRdata = {4'b0, flag, startReq, stopReq, ackEn};
      REG_STATUS: regRdata = statusCode;
      default:    regRdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= cIdle;
      pend       <= pStart;
      nextAct    <= nxAddr;
      dataReg    <= '0;
      ackEn      <= 1'b0;
      stopReq    <= 1'b0;
      startReq   <= 1'b0;
      readMode   <= 1'b0;
      ackSent    <= 1'b0;
      flag       <= 1'b0;
      statusCode <= ST_IDLE;
      cmd        <= '0;
    end else begin
      cmd <= '0;
      if (regWe) begin
        if (regAddr == REG_DATA) dataReg <= regWdata;
        if (regAddr == REG_CTL) begin
          ackEn    <= regWdata[CTL_ACK];
          stopReq  <= regWdata[CTL_STOP];
          startReq <= regWdata[CTL_START];
          if (!regWdata[CTL_FLAG]) flag <= 1'b0;
        end
      end
      unique case (state)
        cIdle: begin
          if (startReq && busFree) begin
            cmd.start <= 1'b1;
            startReq  <= 1'b0;
            pend      <= pStart;
            state     <= cBusy;
          end else if (stopReq) begin
            stopReq <= 1'b0;
          end
        end
        cBusy: begin
          if (dpDone) begin
            state <= cHold;
            flag  <= 1'b1;
            unique case (pend)
              pStart: begin
                statusCode <= ST_START;
                nextAct    <= nxAddr;
              end
              pAddr: begin
                if (dpLost) begin
                  statusCode <= ST_LOST;
                  nextAct    <= nxLost;
                end else if (readMode) begin
                  statusCode <= dpAckIn ? ST_AR_ACK : ST_AR_NACK;
                  nextAct    <= nxRx;
                end else begin
                  statusCode <= dpAckIn ? ST_AW_ACK : ST_AW_NACK;
                  nextAct    <= nxTx;
                end
              end
              pTx: begin
                if (dpLost) begin
                  statusCode <= ST_LOST;
                  nextAct    <= nxLost;
                end else begin
                  statusCode <= dpAckIn ? ST_TX_ACK : ST_TX_NACK;
                end
              end
              pRx: begin
                dataReg    <= dpRxByte;
                statusCode <= ackSent ? ST_RX_ACK : ST_RX_NACK;
              end
              default: begin
                flag       <= 1'b0;
                state      <= cIdle;
                statusCode <= ST_IDLE;
              end
            endcase
          end
        end
        default: begin
          if (!flag) begin
            if (nextAct == nxLost) begin
              state      <= cIdle;
              statusCode <= ST_IDLE;
              stopReq    <= 1'b0;
            end else if (stopReq) begin
              cmd.stop <= 1'b1;
              stopReq  <= 1'b0;
              pend     <= pStop;
              state    <= cBusy;
            end else if (startReq) begin
              cmd.start <= 1'b1;
              startReq  <= 1'b0;
              pend      <= pStart;
              state     <= cBusy;
            end else begin
              state      <= cBusy;
              cmd.byteGo <= 1'b1;
              unique case (nextAct)
                nxAddr: begin
                  readMode <= dataReg[0];
                  pend     <= pAddr;
                end
                nxTx: pend <= pTx;
                default: begin
                  cmd.rxMode <= 1'b1;
                  cmd.ackOut <= ackEn;
                  ackSent    <= ackEn;
                  pend       <= pRx;
                end
              endcase
            end
          end
        end
      endcase
    end
  end

  assert_idle_flag_low_R3: assert property (@(posedge clk) disable iff (!rstN)
    (state == cIdle) |-> !flag);

  assert_stop_selfclear_R9: assert property (@(posedge clk) disable iff (!rstN)
    (state == cBusy && pend == pStop && !regWe) |-> !stopReq);

endmodule

// File: rtl/i2cStsMaster.sv
module i2cStsMaster
  import i2cStsPkg::*;
#(
  parameter int QUARTER = 25
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWe,
  input  logic [1:0] regAddr,
  input  logic [7:0] regWdata,
  output logic [7:0] regRdata,
  output logic       irq,
  input  logic       sclIn,
  input  logic       sdaIn,
  output logic       sclLow,
  output logic       sdaLow
);

  dpCmd_t     cmd;
  logic [7:0] txByte, rxByte, statusCode;
  logic       dpDone, dpLost, dpAckIn;

  i2cStsCtrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .flag(irq), .statusCode(statusCode),
    .cmd(cmd), .txByte(txByte),
    .busFree(sclIn & sdaIn),
    .dpDone(dpDone), .dpLost(dpLost), .dpAckIn(dpAckIn), .dpRxByte(rxByte)
  );

  i2cStsBitEngine #(.QUARTER(QUARTER)) u_engine (
    .clk(clk), .rstN(rstN),
    .cmd(cmd), .txByte(txByte), .sdaIn(sdaIn),
    .sclLow(sclLow), .sdaLow(sdaLow),
    .done(dpDone), .lost(dpLost), .ackIn(dpAckIn), .rxByte(rxByte)
  );

  // parked while the flag is up: the bus is frozen
  assert_hold_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    (irq && $past(irq)) |-> ($stable(sclLow) && $stable(sdaLow)));

  // a reported START leaves the master holding both lines low
  assert_start_lines_R2: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(irq) && statusCode == ST_START) |-> (sclLow && sdaLow));

endmodule

// File: tb/i2cStsMaster_tb.sv
module i2cStsMaster_tb;

  localparam int Q = 3;
  localparam logic [6:0] SLV_ADDR = 7'h52;
  localparam logic [1:0] A_DATA = 2'd0, A_CTL = 2'd1, A_STAT = 2'd2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWe = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic [7:0] regWdata = 8'h00;
  logic [7:0] regRdata;
  logic irq, sclLow, sdaLow;
  logic slvLow = 1'b0;
  logic rivalLow = 1'b0;
  wire sclBus = !sclLow;
  wire sdaBus = !(sdaLow | slvLow | rivalLow);

  int nChecks = 0;
  int nFail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  i2cStsMaster #(.QUARTER(Q)) u_dut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .irq(irq),
    .sclIn(sclBus), .sdaIn(sdaBus), .sclLow(sclLow), .sdaLow(sdaLow)
  );

  function automatic logic [7:0] slvByte(int i);
    return 8'(i * 53 + 17);
  endfunction
  function automatic logic [7:0] expAddr(bit isRead, bit ack);
    return isRead ? (ack ? 8'h40 : 8'h48) : (ack ? 8'h18 : 8'h20);
  endfunction
  function automatic logic [7:0] expTx(bit ack);
    return ack ? 8'h28 : 8'h30;
  endfunction
  function automatic logic [7:0] expRx(bit ackEn);
    return ackEn ? 8'h50 : 8'h58;
  endfunction

  // ---------------- slave bus model (acts at falling clock edges) -------
  logic prevScl = 1'b1, prevSda = 1'b1;
  bit active = 0, isAddr = 0, matched = 0, readMode = 0, sending = 0;
  bit mAckLow = 0, slvAckData = 1;
  int sBit = 0, rdIdx = 0, hiCnt = 0, lastHigh = 0;
  logic [7:0] sShift = 8'h00, txShift = 8'h00, rxLog = 8'h00;

  always @(negedge clk) begin
    if (!rstN) begin
      active = 0; sending = 0; slvLow = 0; prevScl = 1; prevSda = 1;
    end else begin
      if (sclBus && prevScl && prevSda && !sdaBus) begin
        active = 1; sBit = 0; isAddr = 1; matched = 0; sending = 0; slvLow = 0;
      end else if (sclBus && prevScl && !prevSda && sdaBus) begin
        active = 0; sending = 0; slvLow = 0;
      end else if (active && !prevScl && sclBus) begin
        if (sBit < 8) sShift = {sShift[6:0], sdaBus};
        else mAckLow = !sdaBus;
        sBit++;
      end else if (active && prevScl && !sclBus) begin
        if (sBit == 8) begin
          if (isAddr) begin
            matched = (sShift[7:1] == SLV_ADDR);
            readMode = sShift[0];
            slvLow = matched;
          end else if (sending) begin
            slvLow = 0;
          end else begin
            if (matched) rxLog = sShift;
            slvLow = matched && slvAckData;
          end
        end else if (sBit == 9) begin
          sBit = 0;
          if (matched && readMode && (isAddr || (sending && mAckLow))) begin
            sending = 1; txShift = slvByte(rdIdx); rdIdx++; slvLow = !txShift[7];
          end else begin
            sending = 0; slvLow = 0;
          end
          isAddr = 0;
        end else if (sending) begin
          slvLow = !txShift[7 - sBit];
        end
      end
      prevScl = sclBus;
      prevSda = sdaBus;
      if (sclBus) hiCnt++;
      else begin
        if (hiCnt != 0) lastHigh = hiCnt;
        hiCnt = 0;
      end
    end
  end

  // ---------------- helpers ---------------------------------------------
  task automatic chkEq(string tag, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    regAddr = a;
    #1;
    d = regRdata;
  endtask

  task automatic expectFlag(string tag, logic [7:0] exp);
    logic [7:0] s;
    bit ok = 0;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (irq) begin ok = 1; break; end
    end
    chkEq({tag, " flag"}, ok, 1);
    rd(A_STAT, s);
    chkEq(tag, s, exp);
  endtask

  task automatic doStop();
    logic [7:0] s, c;
    bit seenIrq = 0;
    wr(A_CTL, 8'h02);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (irq) seenIrq = 1;
      rd(A_STAT, s); rd(A_CTL, c);
      if (s == 8'hF8 && c[1] == 1'b0) break;
    end
    repeat (4 * Q) @(negedge clk);
    rd(A_STAT, s); rd(A_CTL, c);
    chkEq("R9 status after stop", s, 8'hF8);
    chkEq("R9 stop bit self-clear", c[1], 0);
    chkEq("R3 flag low in idle", seenIrq | irq, 0);
    chkEq("R9 lines released", {sclBus, sdaBus}, 2'b11);
  endtask

  task automatic wrTxn(bit addrOk, int nBytes);
    logic [7:0] d;
    bit ack;
    wr(A_CTL, 8'h04);
    expectFlag("R2 start status", 8'h08);
    wr(A_DATA, {addrOk ? SLV_ADDR : (SLV_ADDR ^ 7'h11), 1'b0});
    wr(A_CTL, 8'h00);
    expectFlag("R4 write address status", expAddr(0, addrOk));
    if (addrOk) begin
      for (int k = 0; k < nBytes; k++) begin
        d = 8'($urandom);
        ack = 1'($urandom);
        slvAckData = ack;
        wr(A_DATA, d);
        wr(A_CTL, 8'h00);
        expectFlag("R5 data status", expTx(ack));
        chkEq("R5 byte seen by slave", rxLog, d);
        chkEq("R11 scl high width", lastHigh, 2 * Q);
      end
    end
    slvAckData = 1;
    doStop();
  endtask

  task automatic rdTxn(bit addrOk, int nBytes);
    logic [7:0] d;
    bit aen;
    int base;
    wr(A_CTL, 8'h04);
    expectFlag("R2 start status", 8'h08);
    base = rdIdx;
    wr(A_DATA, {addrOk ? SLV_ADDR : (SLV_ADDR ^ 7'h0C), 1'b1});
    wr(A_CTL, 8'h00);
    expectFlag("R4 read address status", expAddr(1, addrOk));
    if (addrOk) begin
      for (int k = 0; k < nBytes; k++) begin
        aen = (k != nBytes - 1);
        wr(A_CTL, {7'b0, aen});
        expectFlag("R6 receive status", expRx(aen));
        rd(A_DATA, d);
        chkEq("R6 received byte", d, slvByte(base + k));
        chkEq("R6 ack bit on bus", mAckLow, aen);
      end
    end
    doStop();
  endtask

  // ---------------- watchdog ----------------------------------------------
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nFail++;
      nChecks++;
      $display("FAIL watchdog actual=expired expected=done");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  end

  // ---------------- main sequence -----------------------------------------
  initial begin
    logic [7:0] s, c;
    bit wait08;
    void'($urandom(32'h1C2A5));
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    rd(A_STAT, s); chkEq("R1 reset status", s, 8'hF8);
    rd(A_CTL, c);  chkEq("R1 reset control", c, 8'h00);
    chkEq("R1 reset irq", irq, 0);
    chkEq("R1 reset lines", {sclBus, sdaBus}, 2'b11);

    // directed cases
    wrTxn(1, 2);
    wrTxn(0, 0);
    rdTxn(1, 3);
    rdTxn(1, 1);
    rdTxn(0, 0);

    // constrained random transactions
    for (int t = 0; t < 8; t++) begin
      if ($urandom % 2) wrTxn(1, 1 + ($urandom % 3));
      else rdTxn(1, 1 + ($urandom % 3));
    end

    // arbitration loss, then clear without START
    wr(A_CTL, 8'h04);
    expectFlag("R2 start status", 8'h08);
    rivalLow = 1'b1;
    wr(A_DATA, 8'hA4);
    wr(A_CTL, 8'h00);
    expectFlag("R7 lost status", 8'h38);
    chkEq("R7 scl released", sclBus, 1);
    chkEq("R7 sda not driven", sdaLow, 0);
    wr(A_CTL, 8'h00);
    repeat (3) @(negedge clk);
    rd(A_STAT, s);
    chkEq("R8 idle after lost", s, 8'hF8);
    chkEq("R8 flag low after lost", irq, 0);
    rivalLow = 1'b0;
    repeat (4 * Q) @(negedge clk);

    // arbitration loss, then clear with START while bus is busy
    wr(A_CTL, 8'h04);
    expectFlag("R2 start status", 8'h08);
    rivalLow = 1'b1;
    wr(A_DATA, 8'hC2);
    wr(A_CTL, 8'h00);
    expectFlag("R7 lost status", 8'h38);
    wr(A_CTL, 8'h04);
    wait08 = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (irq) wait08 = 1;
    end
    chkEq("R8 no start while bus busy", wait08, 0);
    rivalLow = 1'b0;
    expectFlag("R8 start after bus free", 8'h08);
    doStop();

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

endmodule